// File: doc/BRIEF.md
# Locked Configuration Port with Key-Sequence Unlock

This block is the configuration front end of an I/O controller. The host reaches it through two byte-wide ports: an index port and a data port. After reset the configuration space is closed. It opens only after a four-byte key arrives on the index port. The last byte of that key depends on which of two base addresses the block is strapped to.

Once the space is open, the host writes a register number to the index port. It then reads or writes that register through the data port. Writing the exit value to the exit register closes the space again.

The register space holds the following:
- a two-byte chip identifier;
- a logical-device select;
- a global flash-decode control byte;
- a 16-bit I/O base for the serial-flash engine, which is visible only in the flash logical device.

The current flash base and the fields of the control byte are driven out continuously, for use by the serial-flash engine. Bus decoding is outside this block. The block sees simple write and read strobes, a port select and a write byte.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the block is locked, flash_base is 0x0820, the logical device is 0, and the control byte is 0x02 (flash_seg_en = 3'b001, all other control outputs 0).
- R2: While locked, four index-port writes of 0x87, 0x01, 0x55 and a last byte unlock the block, and unlocked is high in the cycle after the fourth write. The last byte is 0x55 when strap_alt is 0 (base 0x2E) and 0xAA when strap_alt is 1 (base 0x4E). Any other last byte leaves the block locked.
- R3: While locked, an index write that does not match the next expected key byte sends the matcher back to its first step. If that byte is 0x87, the matcher instead continues with 0x01 as the next expected byte.
- R4: While locked, reads of either port return 0xFF and data-port writes change no register.
- R5: While unlocked, an index-port write selects the register that later data-port accesses use, and an index-port read returns that selection. rd_data takes the read value one cycle after rd_stb and holds it while rd_stb is low.
- R6: While unlocked, a data write of 0x02 with index 0x02 locks the block, and the key must then be sent again from its first byte. A data write of any other value to index 0x02 has no effect.
- R7: Index 0x20 reads the high byte and index 0x21 reads the low byte of the chip ID (0x8716 by default). Both are read-only.
- R8: Index 0x07 is the logical-device select. All 8 bits are readable and writable.
- R9: Index 0x24 is the control byte and is the same in every logical device. Bit 0 drives flash_suspend, bits 3:1 drive flash_seg_en[2:0], bit 4 drives flash_host_wr and bit 5 drives flash_pin_sel. Bits 7:6 read as 0.
- R10: A write to index 0x24 stores bit 4 as 1 only when the written byte also has at least one of bits 3:1 set. Otherwise bit 4 is stored as 0.
- R11: With logical device 7 selected, index 0x64 is the high byte and index 0x65 is the low byte of flash_base. Both are readable and writable. In any other logical device these indices read 0x00 and writes to them are ignored.
- R12: Every other index reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base strap: 0 selects 0x2E (last key byte 0x55), 1 selects 0x4E (last key byte 0xAA) |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_stb |
| unlocked | output | 1 | Configuration space open |
| flash_base | output | 16 | Serial-flash engine I/O base |
| flash_suspend | output | 1 | Control bit 0 |
| flash_seg_en | output | 3 | Control bits 3:1, address segment enables |
| flash_host_wr | output | 1 | Control bit 4, host writes to flash allowed |
| flash_pin_sel | output | 1 | Control bit 5, flash signal pin choice |

## Verification
The assertions assume that strap_alt is static while a key is in flight. They also assume that wr_stb and rd_stb are never high in the same cycle, so a read always sees settled state. The stimulus changes strap_alt only between complete key attempts and issues each access as a strobe of exactly one cycle, with an idle cycle after it. Near-exhaustive sweeps cover every last key byte under both straps and every value written to the control byte. Expected values are computed arithmetically from the requirement text.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // key bytes on the index port
    localparam logic [7:0] KEY_FIRST  = 8'h87;
    localparam logic [7:0] KEY_SECOND = 8'h01;
    localparam logic [7:0] KEY_THIRD  = 8'h55;
    localparam logic [7:0] KEY_LAST_A = 8'h55;   // strap 0, base 0x2E
    localparam logic [7:0] KEY_LAST_B = 8'hAA;   // strap 1, base 0x4E

    // register indices
    localparam logic [7:0] IDX_EXIT   = 8'h02;
    localparam logic [7:0] IDX_LDSEL  = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] IDX_FLCTL  = 8'h24;
    localparam logic [7:0] IDX_FB_HI  = 8'h64;
    localparam logic [7:0] IDX_FB_LO  = 8'h65;

    localparam logic [7:0] EXIT_VALUE = 8'h02;
    localparam logic [7:0] LOCKED_RD  = 8'hFF;

    typedef enum logic [1:0] {
        KS_WAIT0 = 2'd0,
        KS_WAIT1 = 2'd1,
        KS_WAIT2 = 2'd2,
        KS_WAIT3 = 2'd3
    } key_step_e;

    // control byte fields, bit positions are significant
    typedef struct packed {
        logic       pin_sel;   // bit 5
        logic       host_wr;   // bit 4
        logic [2:0] seg_en;    // bits 3:1
        logic       suspend;   // bit 0
    } flash_ctl_t;

    localparam flash_ctl_t FLCTL_RESET = '{pin_sel: 1'b0, host_wr: 1'b0,
                                           seg_en: 3'b001, suspend: 1'b0};

    function automatic logic [7:0] expected_key(key_step_e step, logic alt);
        logic [7:0] b;
        case (step)
            KS_WAIT0: b = KEY_FIRST;
            KS_WAIT1: b = KEY_SECOND;
            KS_WAIT2: b = KEY_THIRD;
            default:  b = alt ? KEY_LAST_B : KEY_LAST_A;
        endcase
        return b;
    endfunction

    // apply the segment-gated host-write rule
    function automatic flash_ctl_t ctl_from_byte(logic [7:0] b);
        flash_ctl_t c;
        c = flash_ctl_t'(b[5:0]);
        if (b[3:1] == 3'b000)
            c.host_wr = 1'b0;
        return c;
    endfunction

    function automatic logic [7:0] ctl_to_byte(flash_ctl_t c);
        return {2'b00, c};
    endfunction

endpackage

// File: rtl/cfgp_key_match.sv
module cfgp_key_match
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_alt,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       open
);

    key_step_e step_q;
    key_step_e step_d;
    logic      open_d;

    always_comb begin
        step_d = step_q;
        open_d = open;
        if (relock) begin
            step_d = KS_WAIT0;
            open_d = 1'b0;
        end else if (key_wr && !open) begin
            if (key_byte == expected_key(step_q, strap_alt)) begin
                if (step_q == KS_WAIT3) begin
                    step_d = KS_WAIT0;
                    open_d = 1'b1;
                end else begin
                    step_d = key_step_e'(step_q + 2'd1);
                end
            end else if (key_byte == KEY_FIRST) begin
                step_d = KS_WAIT1;
            end else begin
                step_d = KS_WAIT0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= KS_WAIT0;
            open   <= 1'b0;
        end else begin
            step_q <= step_d;
            open   <= open_d;
        end
    end

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [7:0]  FLASH_LDN = 8'd7,
    parameter logic [15:0] BASE_RST  = 16'h0820
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        idx_wr,
    input  logic        dat_wr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  index_q,
    output logic [7:0]  rd_value,
    output logic        relock_req,
    output logic [15:0] base_q,
    output flash_ctl_t  ctl_q
);

    localparam logic [7:0] ID_HI = CHIP_ID[15:8];
    localparam logic [7:0] ID_LO = CHIP_ID[7:0];

    logic [7:0] ldsel_q;
    logic       in_flash_ld;

    assign in_flash_ld = (ldsel_q == FLASH_LDN);
    assign relock_req  = dat_wr && (index_q == IDX_EXIT) && (wr_data == EXIT_VALUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            ldsel_q <= 8'h00;
            base_q  <= BASE_RST;
            ctl_q   <= FLCTL_RESET;
        end else begin
            if (idx_wr)
                index_q <= wr_data;
            if (dat_wr) begin
                case (index_q)
                    IDX_LDSEL: ldsel_q <= wr_data;
                    IDX_FLCTL: ctl_q   <= ctl_from_byte(wr_data);
                    IDX_FB_HI: if (in_flash_ld) base_q[15:8] <= wr_data;
                    IDX_FB_LO: if (in_flash_ld) base_q[7:0]  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (index_q)
            IDX_LDSEL: rd_value = ldsel_q;
            IDX_ID_HI: rd_value = ID_HI;
            IDX_ID_LO: rd_value = ID_LO;
            IDX_FLCTL: rd_value = ctl_to_byte(ctl_q);
            IDX_FB_HI: rd_value = in_flash_ld ? base_q[15:8] : 8'h00;
            IDX_FB_LO: rd_value = in_flash_ld ? base_q[7:0]  : 8'h00;
            default:   rd_value = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
    import cfgp_pkg::*;
#(
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [7:0]  FLASH_LDN = 8'd7,
    parameter logic [15:0] BASE_RST  = 16'h0820
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_alt,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic        port_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        unlocked,
    output logic [15:0] flash_base,
    output logic        flash_suspend,
    output logic [2:0]  flash_seg_en,
    output logic        flash_host_wr,
    output logic        flash_pin_sel
);

    logic       idx_wr_any;
    logic       key_wr;
    logic       cfg_idx_wr;
    logic       cfg_dat_wr;
    logic       relock_req;
    logic [7:0] cfg_index;
    logic [7:0] reg_value;
    logic [7:0] rd_mux;
    flash_ctl_t ctl;

    assign idx_wr_any = wr_stb && !port_sel;
    assign key_wr     = idx_wr_any && !unlocked;
    assign cfg_idx_wr = idx_wr_any && unlocked;
    assign cfg_dat_wr = wr_stb && port_sel && unlocked;

    cfgp_key_match u_key (
        .clk       (clk),
        .rst       (rst),
        .strap_alt (strap_alt),
        .key_wr    (key_wr),
        .key_byte  (wr_data),
        .relock    (relock_req),
        .open      (unlocked)
    );

    cfgp_regfile #(
        .CHIP_ID   (CHIP_ID),
        .FLASH_LDN (FLASH_LDN),
        .BASE_RST  (BASE_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .idx_wr     (cfg_idx_wr),
        .dat_wr     (cfg_dat_wr),
        .wr_data    (wr_data),
        .index_q    (cfg_index),
        .rd_value   (reg_value),
        .relock_req (relock_req),
        .base_q     (flash_base),
        .ctl_q      (ctl)
    );

    always_comb begin
        if (!unlocked)
            rd_mux = LOCKED_RD;
        else if (port_sel)
            rd_mux = reg_value;
        else
            rd_mux = cfg_index;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= 8'h00;
        else if (rd_stb)
            rd_data <= rd_mux;
    end

    assign flash_suspend = ctl.suspend;
    assign flash_seg_en  = ctl.seg_en;
    assign flash_host_wr = ctl.host_wr;
    assign flash_pin_sel = ctl.pin_sel;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic        clk,
    input logic        rst,
    input logic        strap_alt,
    input logic        wr_stb,
    input logic        rd_stb,
    input logic        port_sel,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic        unlocked,
    input logic [15:0] flash_base,
    input logic [2:0]  flash_seg_en,
    input logic        flash_host_wr,
    input logic [7:0]  cfg_index
);

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !unlocked); // R1

    AST_UNLOCK_ON_LAST_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(wr_stb && !port_sel &&
            wr_data == (strap_alt ? 8'hAA : 8'h55))); // R2

    AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && rd_stb) |=> rd_data == 8'hFF); // R4

    AST_LOCKED_BASE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(flash_base)); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data)); // R5

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (unlocked && wr_stb && port_sel && cfg_index == 8'h02 && wr_data == 8'h02)
        |=> !unlocked); // R6

    AST_HOSTWR_NEEDS_SEG: assert property (@(posedge clk) disable iff (rst)
        flash_host_wr |-> flash_seg_en != 3'b000); // R10

endmodule

bind cfg_port_unlock cfgp_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .strap_alt     (strap_alt),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .port_sel      (port_sel),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .unlocked      (unlocked),
    .flash_base    (flash_base),
    .flash_seg_en  (flash_seg_en),
    .flash_host_wr (flash_host_wr),
    .cfg_index     (cfg_index)
);

// File: tb/tb_cfg_port_unlock.sv
module tb_cfg_port_unlock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_alt = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        port_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        unlocked;
    logic [15:0] flash_base;
    logic        flash_suspend;
    logic [2:0]  flash_seg_en;
    logic        flash_host_wr;
    logic        flash_pin_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_port_unlock dut (
        .clk           (clk),
        .rst           (rst),
        .strap_alt     (strap_alt),
        .wr_stb        (wr_stb),
        .rd_stb        (rd_stb),
        .port_sel      (port_sel),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .unlocked      (unlocked),
        .flash_base    (flash_base),
        .flash_suspend (flash_suspend),
        .flash_seg_en  (flash_seg_en),
        .flash_host_wr (flash_host_wr),
        .flash_pin_sel (flash_pin_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] b);
        @(negedge clk);
        wr_stb = 1'b1; port_sel = sel; wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1; port_sel = sel;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] v);
        wr(1'b0, idx);
        wr(1'b1, v);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [7:0] v);
        wr(1'b0, idx);
        rd(1'b1, v);
    endtask

    function automatic logic [7:0] last_key(input logic alt);
        return alt ? 8'hAA : 8'h55;
    endfunction

    task automatic send_key();
        wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, last_key(strap_alt));
    endtask

    task automatic relock();
        wreg(8'h02, 8'h02);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] e;
        logic [15:0] base_now;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 unlocked", {31'd0, unlocked}, 32'd0);
        check("R1 flash_base", {16'd0, flash_base}, 32'h0820);
        check("R1 control outputs",
              {26'd0, flash_pin_sel, flash_host_wr, flash_seg_en, flash_suspend}, 32'h02);

        // R4 locked reads and ignored data write
        rd(1'b1, v); check("R4 locked data read", {24'd0, v}, 32'hFF);
        rd(1'b0, v); check("R4 locked index read", {24'd0, v}, 32'hFF);
        wr(1'b1, 8'h00);
        check("R4 locked write outputs",
              {10'd0, flash_base, flash_pin_sel, flash_host_wr, flash_seg_en, flash_suspend},
              {10'd0, 16'h0820, 6'h02});

        // R2 sweep of last key byte, both straps
        for (int s = 0; s < 2; s++) begin
            strap_alt = s[0];
            for (int b = 0; b < 256; b++) begin
                wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, b[7:0]);
                check("R2 last key byte", {31'd0, unlocked},
                      {31'd0, (b[7:0] == last_key(s[0]))});
                if (unlocked) relock();
            end
        end
        strap_alt = 1'b0;

        // R3 restart behaviour
        wr(1'b0, 8'h87); wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
        check("R3 repeated 0x87", {31'd0, unlocked}, 32'd1);
        relock();
        wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h87); wr(1'b0, 8'h01);
        wr(1'b0, 8'h55); wr(1'b0, 8'h55);
        check("R3 0x87 mid-key restarts", {31'd0, unlocked}, 32'd1);
        relock();
        wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h00); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
        check("R3 broken key stays locked", {31'd0, unlocked}, 32'd0);
        wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
        check("R3 tail alone stays locked", {31'd0, unlocked}, 32'd0);

        // R5 index readback
        send_key();
        for (int i = 0; i < 256; i += 37) begin
            wr(1'b0, i[7:0]);
            rd(1'b0, v);
            check("R5 index readback", {24'd0, v}, i);
        end

        // R7 ID registers, read-only
        rreg(8'h20, v); check("R7 id high", {24'd0, v}, 32'h87);
        rreg(8'h21, v); check("R7 id low", {24'd0, v}, 32'h16);
        wreg(8'h20, 8'h00);
        rreg(8'h20, v); check("R7 id high read-only", {24'd0, v}, 32'h87);

        // R8 logical-device select
        wreg(8'h07, 8'hA5);
        rreg(8'h07, v); check("R8 ldsel", {24'd0, v}, 32'hA5);

        // R11 flash base outside flash device
        rreg(8'h64, v); check("R11 base hi outside LD7", {24'd0, v}, 32'h00);
        wreg(8'h64, 8'h55);
        check("R11 write outside LD7 ignored", {16'd0, flash_base}, 32'h0820);
        wreg(8'h07, 8'h07);
        rreg(8'h64, v); check("R11 base hi LD7", {24'd0, v}, 32'h08);
        rreg(8'h65, v); check("R11 base lo LD7", {24'd0, v}, 32'h20);
        wreg(8'h64, 8'h12); wreg(8'h65, 8'h34);
        check("R11 flash_base output", {16'd0, flash_base}, 32'h1234);
        rreg(8'h65, v); check("R11 base lo readback", {24'd0, v}, 32'h34);

        // R9 R10 sweep of control byte from another logical device
        wreg(8'h07, 8'h03);
        for (int b = 0; b < 256; b++) begin
            e = b[7:0] & 8'h3F;
            if ((b & 8'h0E) == 0) e = e & 8'hEF;
            wreg(8'h24, b[7:0]);
            rd(1'b1, v);
            check("R9 R10 control readback", {24'd0, v}, {24'd0, e});
            check("R9 control outputs",
                  {26'd0, flash_pin_sel, flash_host_wr, flash_seg_en, flash_suspend},
                  {24'd0, e});
        end

        // R12 unimplemented index
        wreg(8'h30, 8'h5A);
        rreg(8'h30, v); check("R12 unimplemented reads zero", {24'd0, v}, 32'h00);

        // R6 exit behaviour
        wreg(8'h02, 8'h01);
        check("R6 other value keeps unlocked", {31'd0, unlocked}, 32'd1);
        relock();
        check("R6 exit relocks", {31'd0, unlocked}, 32'd0);
        base_now = flash_base;
        wr(1'b0, 8'h55);
        check("R6 relocked needs full key", {31'd0, unlocked}, 32'd0);
        send_key();
        check("R6 key after relock", {31'd0, unlocked}, 32'd1);
        check("R4 base kept while locked", {16'd0, flash_base}, {16'd0, base_now});
        relock();

        // R2 alternate strap full key
        strap_alt = 1'b1;
        send_key();
        check("R2 alternate strap key", {31'd0, unlocked}, 32'd1);
        relock();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule